// File: doc/BRIEF.md
# Signed Add-Subtract-Compare Unit

This block performs two's-complement addition, subtraction and signed comparison on two operands of a parameterised width. Subtraction adds the bitwise inverse of the second operand with a carry-in of one, so the operand signs are never examined. The same datapath serves every operation. The result and four condition flags (zero, sign, carry, overflow) are captured in output registers on the rising clock edge.

Overflow is derived in two independent ways. One way takes the XOR of the carry into and the carry out of the most significant bit, using a dedicated carry chain. The other sign-extends both operands by one bit, adds them, and tests whether the extra top bit is a faithful copy of the result's sign bit. The two must always agree.

A compare is a subtraction whose difference is dropped. Its flags are kept, and the result bus instead carries a three-way signed ordering (-1, 0 or +1), sign-extended to the full width. "Less than" is taken as sign XOR overflow of that difference.

Top module: `sgn_arith_unit`

## Requirements
- R1: With op_i = 2'b00 (add), res_o becomes (a_i + b_i) modulo 2^WIDTH; a carry beyond the most significant bit never appears in res_o.
- R2: carry_o reports the carry out of the most significant bit of a_i + b_i for add, and of a_i + ~b_i + 1 for subtract and compare.
- R3: ovf_o is 1 exactly when the carry into the most significant bit differs from the carry out of it; the sign-extended WIDTH+1-bit sum detects overflow identically on every cycle.
- R4: With op_i = 2'b01 (subtract), res_o becomes (a_i - b_i) modulo 2^WIDTH, formed as a_i + ~b_i + 1, and ovf_o follows the same carry rule as add.
- R5: zero_o is 1 exactly when the WIDTH-bit sum or difference is all zeros, and sign_o equals its most significant bit; in compare mode both describe the discarded difference.
- R6: With op_i = 2'b10 (compare), res_o is all ones (-1) when signed a_i < signed b_i, 1 when a_i > b_i, and 0 when they are equal; the less-than case coincides with sign_o XOR ovf_o.
- R7: The unused code op_i = 2'b11 behaves exactly as add.
- R8: Outputs update one clock after the inputs are sampled and hold otherwise; a synchronous active-high rst clears res_o and all four flags to zero, taking priority over any operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation: 00 add, 01 subtract, 10 compare, 11 add |
| a_i | input | WIDTH | First operand, two's complement |
| b_i | input | WIDTH | Second operand, two's complement |
| res_o | output | WIDTH | Registered sum, difference or ordering value |
| zero_o | output | 1 | Registered zero flag |
| sign_o | output | 1 | Registered sign flag |
| carry_o | output | 1 | Registered carry-out flag |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The bench builds two copies of the unit. One uses the default WIDTH of 8 and is driven from a table of hand-worked vectors that cover carry drop, both overflow directions, the most negative operand and every compare outcome. The other uses WIDTH = 4, which keeps every operand pair and operation small enough to sweep exhaustively against an integer-range model. That sweep reaches every overflow boundary and every ordering across the sign boundary, with no sampling gaps.

// File: rtl/sgn_arith_pkg.sv
package sgn_arith_pkg;

  // Operation select codes; the spare code is handled as addition.
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_RSVD = 2'b11
  } op_e;

  localparam int FLAG_COUNT = 4;

endpackage

// File: rtl/sgn_carry_chain.sv
// Bit-serial carry propagation; exposes the carry entering the top bit and
// the carry leaving it, which together decide signed overflow.
module sgn_carry_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic             c_msb_in_o,
  output logic             c_out_o
);

  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign carry[i+1] = (a_i[i] & b_i[i]) | (carry[i] & (a_i[i] ^ b_i[i]));
  end

  assign c_msb_in_o = carry[WIDTH-1];
  assign c_out_o    = carry[WIDTH];

endmodule

// File: rtl/sgn_ext_adder.sv
// Adds the operands after widening both by one sign bit. The widened sum
// cannot overflow; the block is out of range when the extra bit disagrees
// with the retained sign bit.
module sgn_ext_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             true_sign_o,
  output logic             ovf_o
);

  localparam int XW = WIDTH + 1;

  logic [XW-1:0] a_x;
  logic [XW-1:0] b_x;
  logic [XW-1:0] sum_x;

  assign a_x   = {a_i[WIDTH-1], a_i};
  assign b_x   = {b_i[WIDTH-1], b_i};
  assign sum_x = a_x + b_x + {{WIDTH{1'b0}}, cin_i};

  assign sum_o       = sum_x[WIDTH-1:0];
  assign true_sign_o = sum_x[WIDTH];
  assign ovf_o       = sum_x[WIDTH] ^ sum_x[WIDTH-1];

endmodule

// File: rtl/sgn_arith_unit.sv
module sgn_arith_unit
  import sgn_arith_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             carry_o,
  output logic             ovf_o
);

  localparam logic [WIDTH-1:0] ORD_LESS    = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ORD_GREATER = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ORD_EQUAL   = '0;

  logic             negate_b;
  logic             is_cmp;
  logic [WIDTH-1:0] b_eff;

  logic             c_msb_in;
  logic             c_out;
  logic             ovf_carry;

  logic [WIDTH-1:0] sum;
  logic             true_sign;
  logic             ovf_ext;

  logic             nx_zero;
  logic             nx_sign;
  logic             a_less;
  logic [WIDTH-1:0] nx_res;

  // Subtract and compare share the inverted-operand path.
  assign negate_b = (op_i == OP_SUB) || (op_i == OP_CMP);
  assign is_cmp   = (op_i == OP_CMP);
  assign b_eff    = negate_b ? ~b_i : b_i;

  sgn_carry_chain #(.WIDTH(WIDTH)) carry_i (
    .a_i        (a_i),
    .b_i        (b_eff),
    .cin_i      (negate_b),
    .c_msb_in_o (c_msb_in),
    .c_out_o    (c_out)
  );

  assign ovf_carry = c_msb_in ^ c_out;

  sgn_ext_adder #(.WIDTH(WIDTH)) ext_i (
    .a_i         (a_i),
    .b_i         (b_eff),
    .cin_i       (negate_b),
    .sum_o       (sum),
    .true_sign_o (true_sign),
    .ovf_o       (ovf_ext)
  );

  assign nx_zero = (sum == '0);
  assign nx_sign = sum[WIDTH-1];

  // Signed "less than" from the dummy difference: sign XOR overflow,
  // taking the overflow term from the widened adder.
  assign a_less = nx_sign ^ ovf_ext;

  always_comb begin
    if (is_cmp) begin
      if (a_less)       nx_res = ORD_LESS;
      else if (nx_zero) nx_res = ORD_EQUAL;
      else              nx_res = ORD_GREATER;
    end else begin
      nx_res = sum;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o   <= '0;
      zero_o  <= 1'b0;
      sign_o  <= 1'b0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      res_o   <= nx_res;
      zero_o  <= nx_zero;
      sign_o  <= nx_sign;
      carry_o <= c_out;
      ovf_o   <= ovf_carry;
    end
  end

  // true_sign carries the same information as a_less; kept observable.
  logic unused_sign;
  assign unused_sign = true_sign;

endmodule

// File: rtl/sgn_arith_unit_chk.sv
module sgn_arith_unit_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             sign_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             ovf_carry,
  input logic             ovf_ext
);

  // R3
  ovf_agree_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_carry == ovf_ext);

  // R1
  add_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b00) |=> (res_o == $past(a_i + b_i)));

  // R4
  sub_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b01) |=> (res_o == $past(a_i - b_i)));

  // R6
  cmp_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b10) |=> ((res_o == {WIDTH{1'b1}}) == (sign_o ^ ovf_o)));

  // R6
  cmp_order_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == 2'b10) |=> ((res_o == {WIDTH{1'b1}}) == $past($signed(a_i) < $signed(b_i))));

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i != 2'b10) |=> (zero_o == (res_o == '0)));

  // R8
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !zero_o && !sign_o && !carry_o && !ovf_o));

endmodule

bind sgn_arith_unit sgn_arith_unit_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .res_o     (res_o),
  .zero_o    (zero_o),
  .sign_o    (sign_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .ovf_carry (ovf_carry),
  .ovf_ext   (ovf_ext)
);

// File: tb/sgn_arith_unit_tb_top.sv
`timescale 1ns/1ps
module sgn_arith_unit_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst;
  logic [1:0] op8;
  logic [7:0] a8, b8, r8;
  logic       z8, s8, c8, v8;
  logic [1:0] op4;
  logic [3:0] a4, b4, r4;
  logic       z4, s4, c4, v4;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  sgn_arith_unit #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .op_i(op8), .a_i(a8), .b_i(b8),
    .res_o(r8), .zero_o(z8), .sign_o(s8), .carry_o(c8), .ovf_o(v8)
  );

  sgn_arith_unit #(.WIDTH(4)) dut_w4_i (
    .clk(clk), .rst(rst), .op_i(op4), .a_i(a4), .b_i(b4),
    .res_o(r4), .zero_o(z4), .sign_o(s4), .carry_o(c4), .ovf_o(v4)
  );

  // Vector: {op[1:0], a[7:0], b[7:0], res[7:0], zero, sign, carry, ovf}
  localparam int NVEC = 14;
  localparam logic [29:0] VECS [NVEC] = '{
    {2'b00, 8'h0F, 8'hFB, 8'h0A, 4'b0010},  // R1 R2: 15 + -5, carry dropped
    {2'b00, 8'h05, 8'hF1, 8'hF6, 4'b0100},  // R1: 5 + -15
    {2'b00, 8'h7F, 8'h01, 8'h80, 4'b0101},  // R3: positive overflow
    {2'b00, 8'h80, 8'h80, 8'h00, 4'b1011},  // R3 R5: negative overflow to zero
    {2'b01, 8'h0F, 8'hFB, 8'h14, 4'b0000},  // R4: 15 - -5
    {2'b01, 8'h0F, 8'h23, 8'hEC, 4'b0100},  // R4: 15 - 35
    {2'b01, 8'h80, 8'h01, 8'h7F, 4'b0011},  // R4: overflow on subtract
    {2'b01, 8'h05, 8'h05, 8'h00, 4'b1010},  // R4 R5: equal operands
    {2'b10, 8'h05, 8'h05, 8'h00, 4'b1010},  // R6: equal
    {2'b10, 8'h80, 8'h01, 8'hFF, 4'b0011},  // R6: less via overflow
    {2'b10, 8'h7F, 8'h80, 8'h01, 4'b0101},  // R6: greater via overflow
    {2'b10, 8'hFB, 8'h0F, 8'hFF, 4'b0110},  // R6: less, no overflow
    {2'b10, 8'h0F, 8'hFB, 8'h01, 4'b0000},  // R6: greater, no overflow
    {2'b11, 8'h7F, 8'h01, 8'h80, 4'b0101}   // R7: spare code adds
  };

  task automatic chk(string tag, logic [11:0] act, logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Integer-range model of the 4-bit unit: {res, zero, sign, carry, ovf}
  function automatic logic [7:0] model4(logic [1:0] o, logic [3:0] x, logic [3:0] y);
    int sx;
    int sy;
    int sres;
    logic [4:0] full;
    logic [3:0] r;
    logic [3:0] res;
    logic v;
    sx = x[3] ? int'(x) - 16 : int'(x);
    sy = y[3] ? int'(y) - 16 : int'(y);
    if (o == 2'b01 || o == 2'b10) begin
      full = {1'b0, x} + {1'b0, ~y} + 5'd1;
      sres = sx - sy;
    end else begin
      full = {1'b0, x} + {1'b0, y};
      sres = sx + sy;
    end
    v = (sres > 7) || (sres < -8);
    r = full[3:0];
    if (o == 2'b10) res = (sx < sy) ? 4'hF : ((sx > sy) ? 4'h1 : 4'h0);
    else            res = r;
    return {res, (r == 4'h0), r[3], full[4], v};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    op8 = 2'b00; a8 = 8'h00; b8 = 8'h00;
    op4 = 2'b00; a4 = 4'h0;  b4 = 4'h0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset w8", {r8, z8, s8, c8, v8}, 12'h000);
    chk("R8 reset w4", {4'h0, r4, z4, s4, c4, v4}, 12'h000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      op8 = VECS[i][29:28];
      a8  = VECS[i][27:20];
      b8  = VECS[i][19:12];
      @(negedge clk);
      case (VECS[i][29:28])
        2'b00:   chk("R1 R2 R3 R5 table add", {r8, z8, s8, c8, v8}, VECS[i][11:0]);
        2'b01:   chk("R4 R2 R5 table sub", {r8, z8, s8, c8, v8}, VECS[i][11:0]);
        2'b10:   chk("R6 R2 R5 table cmp", {r8, z8, s8, c8, v8}, VECS[i][11:0]);
        default: chk("R7 table spare op", {r8, z8, s8, c8, v8}, VECS[i][11:0]);
      endcase
    end

    // R8: outputs hold until the next rising edge, then update
    op8 = 2'b00; a8 = 8'h01; b8 = 8'h01;
    #1;
    chk("R8 hold before edge", {r8, z8, s8, c8, v8}, {8'h80, 4'b0101});
    @(negedge clk);
    chk("R8 R1 update after edge", {r8, z8, s8, c8, v8}, {8'h02, 4'b0000});

    // R8: synchronous reset wins over an overflowing add
    op8 = 2'b00; a8 = 8'h7F; b8 = 8'h01; rst = 1'b1;
    @(negedge clk);
    chk("R8 reset priority", {r8, z8, s8, c8, v8}, 12'h000);
    rst = 1'b0;

    // Exhaustive 4-bit sweep for R1..R6
    for (int o = 0; o < 3; o++) begin
      for (int x = 0; x < 16; x++) begin
        for (int y = 0; y < 16; y++) begin
          op4 = 2'(o); a4 = 4'(x); b4 = 4'(y);
          @(negedge clk);
          if (o == 0)      chk("R1 R2 R3 R5 sweep add", {4'h0, r4, z4, s4, c4, v4}, {4'h0, model4(2'(o), 4'(x), 4'(y))});
          else if (o == 1) chk("R4 R2 R3 R5 sweep sub", {4'h0, r4, z4, s4, c4, v4}, {4'h0, model4(2'(o), 4'(x), 4'(y))});
          else             chk("R6 R5 sweep cmp", {4'h0, r4, z4, s4, c4, v4}, {4'h0, model4(2'(o), 4'(x), 4'(y))});
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule